// File: doc/BRIEF.md
# Single-cycle RISC subset processor

This block is a 32-bit processor that completes every instruction in one clock cycle. It runs a small integer subset: word load and store, add, subtract, bitwise AND, bitwise OR, signed set-less-than, branch-if-equal and an absolute jump. Each cycle the program counter indexes an internal instruction memory. Fields of the fetched word then select one or two registers from a 32-entry register file.

One shared datapath serves all instruction classes. The ALU computes the memory address for loads and stores, the result for arithmetic-logical operations, and the equality test for branches. Three multiplexers choose the second ALU operand (register or sign-extended immediate), the write-back value (ALU or data memory) and the next PC (sequential, branch target or jump target).

The block has only a clock and a synchronous reset as inputs. It exposes the PC and the committed register write as debug outputs. Program and data are placed in the internal memories before reset is released.

Top module: `sc_core`

## Requirements
- R1: While reset is high at a rising edge, the PC becomes 0 and no register write is reported. After release, the first instruction is fetched from address 0.
- R2: Opcode 0x00 with shift field 0 is the register-to-register form. Funct 0x20 adds, 0x22 subtracts (first minus second), 0x24 is bitwise AND and 0x25 is bitwise OR. The result is written to the register named in bits [15:11].
- R3: Funct 0x2A (set-less-than) writes 1 when the register in bits [25:21] is less than the register in bits [20:16] as signed 32-bit integers, and 0 otherwise.
- R4: Opcode 0x23 (load) adds the register in bits [25:21] to the sign-extended bits [15:0]. It writes the data-memory word selected by bits [9:2] of that sum into the register named in bits [20:16].
- R5: Opcode 0x2B (store) writes the register in bits [20:16] to the data-memory word at the same computed address as R4. A store writes no register.
- R6: Opcode 0x04 (branch-if-equal) compares the registers in bits [25:21] and [20:16]. When they are equal, the next PC is PC+4 plus the sign-extended bits [15:0] shifted left by 2. Otherwise the next PC is PC+4. No register is written.
- R7: Opcode 0x02 (jump) sets the next PC to bits [31:28] of PC+4 joined with bits [25:0] shifted left by 2. No register is written.
- R8: Register 0 always reads as zero. A write aimed at register 0 is dropped and is not reported on the debug write port.
- R9: Every instruction other than a branch or jump advances the PC by 4.
- R10: An unknown opcode, an unknown funct, or a nonzero shift field in the register-to-register form writes neither a register nor memory, and the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dbg_pc | output | 32 | Address of the instruction executing this cycle |
| dbg_wr_en | output | 1 | A register write commits at the next rising edge (never for register 0) |
| dbg_wr_addr | output | 5 | Destination register of that write |
| dbg_wr_data | output | 32 | Value being written |

## Verification
The bench builds the block with its default parameters: 32 registers and 256-word instruction and data memories. Memory words are therefore selected by address bits [9:2]. With these defaults, a load whose base plus offset lands on a word boundary is reachable, including a load with a negative offset. A short program also steps the PC through a forward branch that is taken, a branch that is not taken, a backward branch and absolute jumps. The program includes signed-versus-unsigned comparison cases for set-less-than, a write to register 0, and undefined encodings that must leave every register untouched.

// File: rtl/sc_pkg.sv
package sc_pkg;

   localparam logic [5:0] OP_RTYPE = 6'h00;
   localparam logic [5:0] OP_JUMP  = 6'h02;
   localparam logic [5:0] OP_BEQ   = 6'h04;
   localparam logic [5:0] OP_LOAD  = 6'h23;
   localparam logic [5:0] OP_STORE = 6'h2B;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;

   typedef enum logic [2:0] {
      ALU_ADD,
      ALU_SUB,
      ALU_AND,
      ALU_OR,
      ALU_SLT
   } alu_op_e;

   typedef struct packed {
      logic    reg_write;
      logic    dst_is_rd;
      logic    b_is_imm;
      logic    mem_read;
      logic    mem_write;
      logic    branch;
      logic    jump;
      alu_op_e alu_op;
   } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
   import sc_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   input  logic [4:0] shamt,
   output ctrl_t      ctrl
);

   always_comb begin
      ctrl = '0;
      ctrl.alu_op = ALU_ADD;
      unique case (opcode)
         OP_RTYPE: begin
            if (shamt == 5'd0) begin
               unique case (funct)
                  FN_ADD: begin ctrl.reg_write = 1'b1; ctrl.dst_is_rd = 1'b1; ctrl.alu_op = ALU_ADD; end
                  FN_SUB: begin ctrl.reg_write = 1'b1; ctrl.dst_is_rd = 1'b1; ctrl.alu_op = ALU_SUB; end
                  FN_AND: begin ctrl.reg_write = 1'b1; ctrl.dst_is_rd = 1'b1; ctrl.alu_op = ALU_AND; end
                  FN_OR:  begin ctrl.reg_write = 1'b1; ctrl.dst_is_rd = 1'b1; ctrl.alu_op = ALU_OR;  end
                  FN_SLT: begin ctrl.reg_write = 1'b1; ctrl.dst_is_rd = 1'b1; ctrl.alu_op = ALU_SLT; end
                  default: ;
               endcase
            end
         end
         OP_LOAD: begin
            ctrl.reg_write = 1'b1;
            ctrl.b_is_imm  = 1'b1;
            ctrl.mem_read  = 1'b1;
         end
         OP_STORE: begin
            ctrl.b_is_imm  = 1'b1;
            ctrl.mem_write = 1'b1;
         end
         OP_BEQ: begin
            ctrl.branch = 1'b1;
            ctrl.alu_op = ALU_SUB;
         end
         OP_JUMP: begin
            ctrl.jump = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  alu_op_e         op,
   output logic [XLEN-1:0] y,
   output logic            zero
);

   always_comb begin
      unique case (op)
         ALU_SUB: y = a - b;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
         default: y = a + b;
      endcase
   end

   assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
   parameter int XLEN = 32,
   parameter int NREG = 32,
   localparam int RA_W = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            we,
   input  logic [RA_W-1:0] wa,
   input  logic [XLEN-1:0] wd,
   input  logic [RA_W-1:0] ra1,
   input  logic [RA_W-1:0] ra2,
   output logic [XLEN-1:0] rd1,
   output logic [XLEN-1:0] rd2
);

   logic [XLEN-1:0] regs [NREG];

   always_ff @(posedge clk) begin
      if (we && (wa != '0)) regs[wa] <= wd;
   end

   assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
   assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/sc_word_mem.sv
module sc_word_mem #(
   parameter int XLEN  = 32,
   parameter int WORDS = 256,
   localparam int IX_W = $clog2(WORDS)
) (
   input  logic            clk,
   input  logic            we,
   input  logic [IX_W-1:0] idx,
   input  logic [XLEN-1:0] wdata,
   output logic [XLEN-1:0] rdata
);

   logic [XLEN-1:0] words [WORDS];

   always_ff @(posedge clk) begin
      if (we) words[idx] <= wdata;
   end

   assign rdata = words[idx];

endmodule

// File: rtl/sc_core.sv
module sc_core
   import sc_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int NREG       = 32,
   parameter int IMEM_WORDS = 256,
   parameter int DMEM_WORDS = 256,
   localparam int RA_W = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst,
   output logic [XLEN-1:0] dbg_pc,
   output logic            dbg_wr_en,
   output logic [RA_W-1:0] dbg_wr_addr,
   output logic [XLEN-1:0] dbg_wr_data
);

   localparam int IM_W = $clog2(IMEM_WORDS);
   localparam int DM_W = $clog2(DMEM_WORDS);

   // elaboration-time parameter checks
   if (XLEN != 32) begin : g_bad_xlen
      $error("sc_core: XLEN must be 32");
   end
   if (NREG != 32) begin : g_bad_nreg
      $error("sc_core: NREG must be 32");
   end
   if ((IMEM_WORDS < 256) || ((1 << IM_W) != IMEM_WORDS)) begin : g_bad_imem
      $error("sc_core: IMEM_WORDS must be a power of two, at least 256");
   end
   if ((DMEM_WORDS < 256) || ((1 << DM_W) != DMEM_WORDS)) begin : g_bad_dmem
      $error("sc_core: DMEM_WORDS must be a power of two, at least 256");
   end

   logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_target, j_target;
   logic [XLEN-1:0] instr, rs_val, rt_val, imm_ext, alu_b, alu_y;
   logic [XLEN-1:0] dmem_rdata, wb_data;
   logic            alu_zero, take_br, rf_we;
   logic [RA_W-1:0] wr_addr;
   ctrl_t           ctrl;

   // program counter
   always_ff @(posedge clk) begin
      if (rst) pc_q <= '0;
      else     pc_q <= pc_next;
   end

   sc_word_mem #(.XLEN(XLEN), .WORDS(IMEM_WORDS)) u_imem (
      .clk   (clk),
      .we    (1'b0),
      .idx   (pc_q[IM_W+1:2]),
      .wdata ('0),
      .rdata (instr)
   );

   sc_decode u_dec (
      .opcode (instr[31:26]),
      .funct  (instr[5:0]),
      .shamt  (instr[10:6]),
      .ctrl   (ctrl)
   );

   assign wr_addr = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];
   assign rf_we   = ctrl.reg_write & ~rst;

   sc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
      .clk (clk),
      .we  (rf_we),
      .wa  (wr_addr),
      .wd  (wb_data),
      .ra1 (instr[25:21]),
      .ra2 (instr[20:16]),
      .rd1 (rs_val),
      .rd2 (rt_val)
   );

   // operand select
   assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
   assign alu_b   = ctrl.b_is_imm ? imm_ext : rt_val;

   sc_alu #(.XLEN(XLEN)) u_alu (
      .a    (rs_val),
      .b    (alu_b),
      .op   (ctrl.alu_op),
      .y    (alu_y),
      .zero (alu_zero)
   );

   sc_word_mem #(.XLEN(XLEN), .WORDS(DMEM_WORDS)) u_dmem (
      .clk   (clk),
      .we    (ctrl.mem_write & ~rst),
      .idx   (alu_y[DM_W+1:2]),
      .wdata (rt_val),
      .rdata (dmem_rdata)
   );

   // write-back select
   assign wb_data = ctrl.mem_read ? dmem_rdata : alu_y;

   // next-PC select
   assign pc_plus4  = pc_q + 32'd4;
   assign br_target = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
   assign j_target  = {pc_plus4[31:28], instr[25:0], 2'b00};
   assign take_br   = ctrl.branch & alu_zero;
   assign pc_next   = ctrl.jump ? j_target : (take_br ? br_target : pc_plus4);

   assign dbg_pc      = pc_q;
   assign dbg_wr_en   = rf_we & (wr_addr != '0);
   assign dbg_wr_addr = wr_addr;
   assign dbg_wr_data = wb_data;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk #(
   parameter int XLEN = 32,
   parameter int NREG = 32,
   localparam int RA_W = $clog2(NREG)
) (
   input logic            clk,
   input logic            rst,
   input logic [XLEN-1:0] pc,
   input logic [XLEN-1:0] instr,
   input logic [XLEN-1:0] rs_val,
   input logic [XLEN-1:0] rt_val,
   input logic [XLEN-1:0] dmem_rdata,
   input logic            wr_en,
   input logic [RA_W-1:0] wr_addr,
   input logic [XLEN-1:0] wr_data
);

   logic [5:0] op;
   logic       known_op;
   assign op       = instr[31:26];
   assign known_op = (op == 6'h00) || (op == 6'h02) || (op == 6'h04) ||
                     (op == 6'h23) || (op == 6'h2B);

   p_reset_pc_r1: assert property (@(posedge clk) rst |=> pc == '0);

   p_load_wb_r4: assert property (@(posedge clk) disable iff (rst)
      (op == 6'h23) && wr_en |-> wr_data == dmem_rdata);

   p_store_silent_r5: assert property (@(posedge clk) disable iff (rst)
      (op == 6'h2B) |-> !wr_en);

   p_beq_taken_r6: assert property (@(posedge clk) disable iff (rst)
      (op == 6'h04) && (rs_val == rt_val) |=>
      pc == $past(pc) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});

   p_beq_fall_r6: assert property (@(posedge clk) disable iff (rst)
      (op == 6'h04) && (rs_val != rt_val) |=> pc == $past(pc) + 32'd4);

   p_jump_r7: assert property (@(posedge clk) disable iff (rst)
      (op == 6'h02) |=>
      pc == {$past(pc[31:28] + (&$past(pc[27:2]) ? 4'd1 : 4'd0)), $past(instr[25:0]), 2'b00});

   p_zero_read_r8: assert property (@(posedge clk) disable iff (rst)
      (instr[25:21] == 5'd0) |-> rs_val == '0);

   p_zero_write_r8: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> wr_addr != '0);

   p_seq_r9: assert property (@(posedge clk) disable iff (rst)
      (op != 6'h04) && (op != 6'h02) |=> pc == $past(pc) + 32'd4);

   p_undef_r10: assert property (@(posedge clk) disable iff (rst)
      !known_op |-> !wr_en);

endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN), .NREG(NREG)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .pc         (pc_q),
   .instr      (instr),
   .rs_val     (rs_val),
   .rt_val     (rt_val),
   .dmem_rdata (dmem_rdata),
   .wr_en      (dbg_wr_en),
   .wr_addr    (dbg_wr_addr),
   .wr_data    (dbg_wr_data)
);

// File: tb/sc_core_tb_top.sv
`timescale 1ns/1ps
module sc_core_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] dbg_pc;
   logic        dbg_wr_en;
   logic [4:0]  dbg_wr_addr;
   logic [31:0] dbg_wr_data;

   int errors = 0;
   int checks = 0;
   bit run    = 1'b0;

   typedef struct {
      logic [4:0]  addr;
      logic [31:0] data;
      string       tag;
   } wr_item_t;

   typedef struct {
      logic [31:0] pc;
      string       tag;
   } pc_item_t;

   wr_item_t exp_wr[$];
   pc_item_t exp_pc[$];

   always #2 clk = ~clk;   // 250 MHz

   sc_core dut_i (
      .clk         (clk),
      .rst         (rst),
      .dbg_pc      (dbg_pc),
      .dbg_wr_en   (dbg_wr_en),
      .dbg_wr_addr (dbg_wr_addr),
      .dbg_wr_data (dbg_wr_data)
   );

   function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
      return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
   endfunction
   function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
      return {op, rs[4:0], rt[4:0], imm[15:0]};
   endfunction
   function automatic logic [31:0] enc_j(input int idx);
      return {6'h02, idx[25:0]};
   endfunction

   task automatic push_wr(input int a, input logic [31:0] d, input string tag);
      wr_item_t it;
      it.addr = a[4:0]; it.data = d; it.tag = tag;
      exp_wr.push_back(it);
   endtask
   task automatic push_pc(input logic [31:0] p, input string tag);
      pc_item_t it;
      it.pc = p; it.tag = tag;
      exp_pc.push_back(it);
   endtask

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: compare PC and write port against the scoreboard
   always @(negedge clk) begin
      if (run) begin
         if (exp_pc.size() == 0) check(1'b0, "R9 pc queue empty", 64'(dbg_pc), 64'hX);
         else begin
            pc_item_t p;
            p = exp_pc.pop_front();
            check(dbg_pc === p.pc, p.tag, 64'(dbg_pc), 64'(p.pc));
         end
         if (dbg_wr_en === 1'b1) begin
            if (exp_wr.size() == 0)
               check(1'b0, "R10 unexpected write", {27'd0, dbg_wr_addr, dbg_wr_data}, 64'd0);
            else begin
               wr_item_t w;
               w = exp_wr.pop_front();
               check((dbg_wr_addr === w.addr) && (dbg_wr_data === w.data), w.tag,
                     {27'd0, dbg_wr_addr, dbg_wr_data}, {27'd0, w.addr, w.data});
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (2000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // data memory preload
      dut_i.u_dmem.words[0] = 32'd5;
      dut_i.u_dmem.words[1] = 32'hFFFF_FFFD;
      dut_i.u_dmem.words[2] = 32'h7FFF_FFF0;
      // program
      dut_i.u_imem.words[0]  = enc_i(6'h23, 0, 1, 0);
      dut_i.u_imem.words[1]  = enc_i(6'h23, 0, 2, 4);
      dut_i.u_imem.words[2]  = enc_i(6'h23, 0, 3, 8);
      dut_i.u_imem.words[3]  = enc_r(1, 2, 4, 6'h20);
      dut_i.u_imem.words[4]  = enc_r(1, 2, 5, 6'h22);
      dut_i.u_imem.words[5]  = enc_r(2, 3, 6, 6'h24);
      dut_i.u_imem.words[6]  = enc_r(1, 2, 7, 6'h25);
      dut_i.u_imem.words[7]  = enc_r(2, 1, 8, 6'h2A);
      dut_i.u_imem.words[8]  = enc_r(1, 2, 9, 6'h2A);
      dut_i.u_imem.words[9]  = enc_r(3, 2, 10, 6'h2A);
      dut_i.u_imem.words[10] = enc_r(1, 1, 0, 6'h20);
      dut_i.u_imem.words[11] = enc_r(0, 1, 11, 6'h20);
      dut_i.u_imem.words[12] = enc_i(6'h2B, 0, 4, 12);
      dut_i.u_imem.words[13] = enc_i(6'h23, 0, 12, 12);
      dut_i.u_imem.words[14] = enc_i(6'h2B, 0, 5, 16);
      dut_i.u_imem.words[15] = enc_i(6'h23, 1, 13, 11);
      dut_i.u_imem.words[16] = enc_i(6'h23, 13, 14, -4);
      dut_i.u_imem.words[17] = enc_i(6'h04, 1, 2, 5);
      dut_i.u_imem.words[18] = enc_i(6'h04, 1, 11, 2);
      dut_i.u_imem.words[19] = enc_r(1, 1, 15, 6'h20);
      dut_i.u_imem.words[20] = enc_r(1, 1, 15, 6'h20);
      dut_i.u_imem.words[21] = 32'hFC00_0000;
      dut_i.u_imem.words[22] = enc_r(1, 1, 16, 6'h27);
      dut_i.u_imem.words[23] = enc_j(30);
      for (int i = 24; i < 27; i++) dut_i.u_imem.words[i] = enc_r(1, 1, 15, 6'h20);
      dut_i.u_imem.words[27] = enc_r(1, 4, 16, 6'h20);
      dut_i.u_imem.words[28] = enc_j(31);
      dut_i.u_imem.words[29] = enc_r(1, 1, 15, 6'h20);
      dut_i.u_imem.words[30] = enc_i(6'h04, 0, 0, -4);
      dut_i.u_imem.words[31] = enc_j(31);

      // expected PC trace
      for (int i = 0; i < 17; i++) push_pc(32'(4 * i), "R9 sequential pc");
      push_pc(32'd68, "R9 pc after load");
      push_pc(32'd72, "R6 branch not taken");
      push_pc(32'd84, "R6 forward branch taken");
      push_pc(32'd88, "R10 undefined opcode advances");
      push_pc(32'd92, "R10 undefined funct advances");
      push_pc(32'd120, "R7 jump target");
      push_pc(32'd108, "R6 backward branch taken");
      push_pc(32'd112, "R9 pc after add");
      push_pc(32'd124, "R7 second jump target");
      push_pc(32'd124, "R7 jump to self");

      // expected writes
      push_wr(1, 32'd5, "R4 load word 0");
      push_wr(2, 32'hFFFF_FFFD, "R4 load word 1");
      push_wr(3, 32'h7FFF_FFF0, "R4 load word 2");
      push_wr(4, 32'd2, "R2 add");
      push_wr(5, 32'd8, "R2 sub");
      push_wr(6, 32'h7FFF_FFF0, "R2 and");
      push_wr(7, 32'hFFFF_FFFD, "R2 or");
      push_wr(8, 32'd1, "R3 slt negative<positive");
      push_wr(9, 32'd0, "R3 slt positive<negative");
      push_wr(10, 32'd0, "R3 slt signed not unsigned");
      push_wr(11, 32'd5, "R8 register 0 reads zero after write");
      push_wr(12, 32'd2, "R5 stored value read back");
      push_wr(13, 32'd8, "R4 base plus offset");
      push_wr(14, 32'hFFFF_FFFD, "R4 negative offset");
      push_wr(16, 32'd7, "R7 jump path executes");

      // reset phase
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(dbg_pc === 32'd0, "R1 pc in reset", 64'(dbg_pc), 64'd0);
      check(dbg_wr_en === 1'b0, "R1 no write in reset", 64'(dbg_wr_en), 64'd0);
      @(posedge clk);
      #1;
      rst = 1'b0;
      run = 1'b1;
      repeat (27) @(posedge clk);
      #1;
      run = 1'b0;
      check(exp_pc.size() == 0, "R9 all pc items seen", 64'(exp_pc.size()), 64'd0);
      check(exp_wr.size() == 0, "R5 all writes seen", 64'(exp_wr.size()), 64'd0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule